// File: doc/BRIEF.md
# CTS Change Interrupt Status

This block watches the clear-to-send modem input of a serial port and records any change of level in a raw interrupt status bit. Software sees that bit, a mask bit, and the masked result through a small register port. A single interrupt line reports any masked status that is set. Everything runs on the serial port's own clock.

Software clears the status through a write-only clear register. The status does not clear on the written value. It clears when a hidden clear-request flop moves from 0 to 1. Hardware returns that flop to 0 only while the status is low. If a new CTS change arrives in the same cycle as a clear, the new change wins and the flop stays at 1. In that case a repeated write of 1 does nothing. Software must first write 0, hold it for one clock, and then write 1.

Top module: `cts_irq_ctrl`

## Requirements
- R1: Reset clears the raw status, the mask and the interrupt line. If CTS is already high while reset is held or released, no status is set afterwards.
- R2: A rising level on CTS sets the raw status (bit 1 of the read data at address 0) within four clocks.
- R3: A falling level on CTS also sets the raw status.
- R4: Writing 1 to bit 1 at address 3 clears the raw status when the clear-request flop was 0 before the write. Writing 0 there never clears the status.
- R5: While the raw status is 0, hardware returns the clear-request flop to 0. A later edge can therefore be cleared by a single write of 1.
- R6: When a CTS change is detected in the same cycle as a clearing write, the status stays 1. Any further writes of 1 alone leave it at 1.
- R7: A write of 0 followed one clock later by a write of 1 at address 3 clears a status left stuck as in R6.
- R8: Address 3 always reads as zero. The clear-request flop is never visible.
- R9: Address 1 reads back the mask. Only bit 1 is stored and every other bit reads 0.
- R10: Address 2 reads the raw status ANDed with the mask at bit 1. The interrupt output is high exactly when that masked bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_o | output | 1 | Interrupt, OR of masked status bits |

## Verification
A clear-request flop that does not return to 0 shows up on the next edge after a clean clear: a single write of 1 leaves address 0 reading 2 one clock after the write. A flop that is reset too eagerly shows up in the race case: the stuck status clears on a repeated write of 1 instead of holding. A missing or misordered priority between set and clear shows up in that same race cycle, because raw status reads 0 on the clock after the colliding write. Synchronizer or arming faults show up as a status set after reset with CTS high, or as an edge that never lands within four clocks.

// File: rtl/cts_irq_ctrl.sv
`timescale 1ns/1ps
module cts_irq_ctrl #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int CTS_BIT     = 1,
  parameter int SYNC_STAGES = 2,
  parameter int RAW_ADDR    = 0,
  parameter int MASK_ADDR   = 1,
  parameter int MIS_ADDR    = 2,
  parameter int CLR_ADDR    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(RAW_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] A_MIS  = ADDR_W'(MIS_ADDR);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES:0]   arm_q;
  logic                   prev_q;
  logic                   raw_q;
  logic                   mask_q;
  logic                   clr_q;

  logic edge_ok, wr_mask, wr_clr, clr_bit, clr_rise;
  logic [DATA_W-1:0] raw_vec, mask_vec, mis_vec;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      arm_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cts_i};
      arm_q  <= {arm_q[SYNC_STAGES-1:0], 1'b1};
      prev_q <= sync_q[LAST];
    end
  end

  assign edge_ok  = arm_q[SYNC_STAGES] & (sync_q[LAST] ^ prev_q);
  assign wr_mask  = reg_wr & (reg_addr == A_MASK);
  assign wr_clr   = reg_wr & (reg_addr == A_CLR);
  assign clr_bit  = reg_wdata[CTS_BIT];
  assign clr_rise = wr_clr & clr_bit & ~clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      clr_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (edge_ok)       raw_q <= 1'b1;
      else if (clr_rise) raw_q <= 1'b0;

      if (wr_clr)      clr_q <= clr_bit;
      else if (!raw_q) clr_q <= 1'b0;

      if (wr_mask) mask_q <= reg_wdata[CTS_BIT];
    end
  end

  always_comb begin
    raw_vec  = '0;
    mask_vec = '0;
    raw_vec[CTS_BIT]  = raw_q;
    mask_vec[CTS_BIT] = mask_q;
    mis_vec = raw_vec & mask_vec;
    case (reg_addr)
      A_RAW:   reg_rdata = raw_vec;
      A_MASK:  reg_rdata = mask_vec;
      A_MIS:   reg_rdata = mis_vec;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o = |mis_vec;

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ok |=> raw_q);

  a_r4_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && clr_rise && !edge_ok) |=> !raw_q);

  a_r4_hold_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !edge_ok && !(wr_clr && clr_bit && !clr_q)) |=> raw_q);

  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_q && !wr_clr) |=> !clr_q);

  a_r6_stuck_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && clr_q && wr_clr && clr_bit) |=> raw_q);

  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q && !wr_mask) |=> !irq_o);

endmodule

// File: tb/cts_irq_ctrl_test.sv
`timescale 1ns/1ps
module cts_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_i = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cts_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cts_i(cts_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  // {cts, wr, waddr[1:0], wdata[7:0], raddr[1:0], exp_rdata[7:0], exp_irq}
  localparam int N = 13;
  localparam logic [22:0] TBL [N] = '{
    {1'b0, 1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 1'b0}, // R1 idle
    {1'b1, 1'b1, 2'd1, 8'h02, 2'd0, 8'h02, 1'b1}, // R2 rise, R10 irq
    {1'b1, 1'b1, 2'd3, 8'h02, 2'd0, 8'h00, 1'b0}, // R4 clear
    {1'b0, 1'b0, 2'd0, 8'h00, 2'd2, 8'h02, 1'b1}, // R3 fall, R10 masked
    {1'b0, 1'b1, 2'd1, 8'h00, 2'd2, 8'h00, 1'b0}, // R10 mask off
    {1'b0, 1'b0, 2'd0, 8'h00, 2'd0, 8'h02, 1'b0}, // R10 raw kept
    {1'b0, 1'b1, 2'd3, 8'h02, 2'd1, 8'h00, 1'b0}, // R5 second clear, R9
    {1'b0, 1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 1'b0}, // R5 cleared
    {1'b1, 1'b1, 2'd3, 8'h00, 2'd0, 8'h02, 1'b0}, // R4 zero write no clear
    {1'b1, 1'b1, 2'd3, 8'h02, 2'd3, 8'h00, 1'b0}, // R8 reads zero
    {1'b1, 1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 1'b0}, // R4 cleared
    {1'b1, 1'b1, 2'd1, 8'hFF, 2'd1, 8'h02, 1'b0}, // R9 only bit 1
    {1'b0, 1'b0, 2'd0, 8'h00, 2'd2, 8'h02, 1'b1}  // R3 R10
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a,
                        input logic [7:0] exp, input logic exp_irq);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    chk({tag, " irq"}, {7'd0, irq_o}, {7'd0, exp_irq});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rd_chk("R1 reset raw", 2'd0, 8'h00, 1'b0);
    rst_n = 1'b1;
    idle(2);

    for (int i = 0; i < N; i++) begin
      cts_i = TBL[i][22];
      if (TBL[i][21]) wr(TBL[i][20:19], TBL[i][18:11]);
      else idle(1);
      idle(5);
      rd_chk($sformatf("table step %0d", i), TBL[i][10:9], TBL[i][8:1], TBL[i][0]);
    end

    // R6 race: edge lands in the same cycle as the clearing write
    rd_chk("R6 pre raw", 2'd0, 8'h02, 1'b1);
    cts_i = 1'b1;
    idle(2);
    wr(2'd3, 8'h02);
    idle(3);
    rd_chk("R6 set wins", 2'd0, 8'h02, 1'b1);
    wr(2'd3, 8'h02);
    idle(1);
    rd_chk("R6 repeat one stuck", 2'd0, 8'h02, 1'b1);
    wr(2'd3, 8'h02);
    idle(1);
    rd_chk("R6 repeat two stuck", 2'd0, 8'h02, 1'b1);
    // R7 re-arm with a zero held one clock
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h02);
    rd_chk("R7 rearm clears", 2'd0, 8'h00, 1'b0);
    idle(2);
    rd_chk("R7 stays clear", 2'd0, 8'h00, 1'b0);

    // R1 reset with CTS high gives no false edge
    cts_i = 1'b1;
    rst_n = 1'b0;
    idle(2);
    rd_chk("R1 mask in reset", 2'd1, 8'h00, 1'b0);
    rst_n = 1'b1;
    idle(8);
    rd_chk("R1 no false edge", 2'd0, 8'h00, 1'b0);
    rd_chk("R1 mask after reset", 2'd1, 8'h00, 1'b0);
    // R2 edge latency within four clocks
    cts_i = 1'b0;
    idle(4);
    rd_chk("R2 latency", 2'd0, 8'h02, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule